// File: doc/BRIEF.md
# UART Transmitter with Elaboration-Time Framing

This block turns words held in an external transmit FIFO into asynchronous serial frames on a single line. An internal modulo counter divides the system clock down to an enable pulse at sixteen times the baud rate, and every bit of a frame lasts sixteen of these pulses. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period is given in enable pulses, so 16, 24 or 32 give one, one and a half or two stop bits.

The FIFO sits outside the block. The block looks at its "not empty" flag and reads its head word. It returns a one-cycle pop strobe when it takes a word. At the end of each stop period it raises a one-cycle done pulse. If another word is waiting, the next frame starts on the following clock with no idle time between frames.

The state machine has five states. ST_IDLE holds the line high until an enable pulse finds the FIFO not empty, then loads the word and moves to ST_START (idle to start). ST_START drives the start bit for 16 pulses and moves to ST_DATA (start to data). ST_DATA shifts out the data bits. After the last data bit it moves to ST_PARITY when parity is on (data to parity) or to ST_STOP when parity is off (data to stop). ST_PARITY drives the parity bit for 16 pulses and moves to ST_STOP (parity to stop). At the end of the stop period ST_STOP goes back to ST_START if the FIFO has data (stop to start) and to ST_IDLE if it does not (stop to idle).

Top module: `uart_tx_framer`

## Requirements
- R1: While rst is high, tx is 1 and fifo_pop and tx_done are 0.
- R2: While the FIFO flag is low and no frame is in progress, tx stays 1 and fifo_pop stays 0.
- R3: The internal enable pulse occurs once every DIVISOR clocks, and each start, data and parity bit lasts exactly 16 pulses, which is 16*DIVISOR clocks.
- R4: A frame begins with tx at 0 for one bit period. The word is taken from the FIFO with fifo_pop high for exactly one clock, only while fifo_nempty is 1, and tx is 0 on the clock that follows.
- R5: After the start bit, DATA_BITS data bits (7, 8 or 9) follow, bit 0 first.
- R6: PARITY selects the parity bit: 0 sends none, 1 (even) sends the XOR of the data bits, and 2 (odd) sends its inverse. The parity bit directly follows the last data bit.
- R7: After the last data or parity bit, tx is 1 for STOP_TICKS enable pulses (16, 24 or 32).
- R8: tx_done is high for exactly one clock. That clock is the last clock of the stop period, which is frame length minus one clocks after the clock in which tx first goes low.
- R9: If fifo_nempty is 1 when the stop period ends, fifo_pop is asserted in that same clock and the next start bit begins one full frame length after the previous one. Otherwise the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_BITS | Word at the head of the transmit FIFO |
| fifo_nempty | input | 1 | FIFO holds at least one word |
| fifo_pop | output | 1 | One-clock strobe that removes the head word |
| tx | output | 1 | Serial line, idle high |
| tx_done | output | 1 | One-clock pulse at the end of each frame |

## Verification
The bench runs three framings side by side: 8 data bits with odd parity and one stop bit, 7 bits with even parity and one and a half stop bits, and 9 bits with no parity and two stop bits. Each uses a different clock divisor, so a wrong bit count, a wrong parity sense, a missing parity state or a wrong stop length shows up in at least one of them. Each framing is fed all-zero, all-one and alternating words, which separate bit order and parity polarity, followed by random words. Words arrive both in bursts, where exact frame-to-frame spacing checks the stop-to-start path, and after idle gaps, which check that the line stays quiet and that the stop-to-idle path is taken.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int OS_RATE  = 16;
    localparam int PAR_NONE = 0;
    localparam int PAR_EVEN = 1;
    localparam int PAR_ODD  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
    parameter int DIVISOR = 326,
    parameter int DIV_W   = 9
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIVISOR - 1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int PARITY     = PAR_NONE,
    parameter int STOP_TICKS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 fifo_nempty,
    output logic                 fifo_pop,
    output logic                 tx,
    output logic                 tx_done
);
    localparam int  TMAX    = (STOP_TICKS > OS_RATE) ? STOP_TICKS : OS_RATE;
    localparam int  TW      = $clog2(TMAX);
    localparam int  BW      = $clog2(DATA_BITS);
    localparam bit  HAS_PAR = (PARITY != PAR_NONE);
    localparam logic [TW-1:0] BIT_LAST  = TW'(OS_RATE - 1);
    localparam logic [TW-1:0] STOP_LAST = TW'(STOP_TICKS - 1);
    localparam logic [BW-1:0] DATA_LAST = BW'(DATA_BITS - 1);

    tx_state_t            state;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bcnt;
    logic [DATA_BITS-1:0] sreg;
    logic                 pbit;
    logic                 bit_end;
    logic                 stop_end;
    logic                 load;

    function automatic logic parity_of(input logic [DATA_BITS-1:0] d);
        if (PARITY == PAR_EVEN) return ^d;
        if (PARITY == PAR_ODD)  return ~^d;
        return 1'b0;
    endfunction

    assign bit_end  = tick && (tcnt == BIT_LAST);
    assign stop_end = tick && (tcnt == STOP_LAST) && (state == ST_STOP);
    assign load     = tick && fifo_nempty &&
                      ((state == ST_IDLE) || ((state == ST_STOP) && (tcnt == STOP_LAST)));

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            sreg  <= '0;
            pbit  <= 1'b0;
        end else begin
            if (load) begin
                sreg <= din;
                pbit <= parity_of(din);
            end
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        tcnt <= '0;
                        if (fifo_nempty) state <= ST_START;
                    end
                    ST_START: begin
                        if (bit_end) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= ST_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (bit_end) begin
                            tcnt <= '0;
                            sreg <= sreg >> 1;
                            if (bcnt == DATA_LAST) begin
                                state <= HAS_PAR ? ST_PARITY : ST_STOP;
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        if (bit_end) begin
                            tcnt  <= '0;
                            state <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == STOP_LAST) begin
                            tcnt  <= '0;
                            state <= fifo_nempty ? ST_START : ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        fifo_pop = load;
        tx_done  = stop_end;
        unique case (state)
            ST_IDLE:   tx = 1'b1;
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = sreg[0];
            ST_PARITY: tx = pbit;
            ST_STOP:   tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int PARITY     = PAR_NONE,
    parameter int STOP_TICKS = 16,
    parameter int DIVISOR    = 326,
    parameter int DIV_W      = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 fifo_nempty,
    output logic                 fifo_pop,
    output logic                 tx,
    output logic                 tx_done
);
    logic os_tick;

    uart_baud_div #(
        .DIVISOR(DIVISOR),
        .DIV_W  (DIV_W)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .tick(os_tick)
    );

    uart_tx_fsm #(
        .DATA_BITS (DATA_BITS),
        .PARITY    (PARITY),
        .STOP_TICKS(STOP_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .din        (din),
        .fifo_nempty(fifo_nempty),
        .fifo_pop   (fifo_pop),
        .tx         (tx),
        .tx_done    (tx_done)
    );
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk #(
    parameter int DIVISOR = 326
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic fifo_nempty,
    input logic fifo_pop,
    input logic tx,
    input logic tx_done
);
    int gap;

    always_ff @(posedge clk) begin
        if (rst || tick) gap <= 0;
        else             gap <= gap + 1;
    end

    assert_tick_period_R3: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == DIVISOR - 1));

    assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_nempty);

    assert_pop_then_start_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !tx);

    assert_pop_single_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    assert_done_line_high_R7: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    assert_backlog_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_done && fifo_nempty) |-> fifo_pop);
endmodule

bind uart_tx_framer uart_tx_framer_chk #(.DIVISOR(DIVISOR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .fifo_nempty(fifo_nempty),
    .fifo_pop   (fifo_pop),
    .tx         (tx),
    .tx_done    (tx_done)
);

// File: tb/uart_tx_framer_test.sv
module tx_lane #(
    parameter int DW    = 8,
    parameter int PAR   = 0,
    parameter int STOPT = 16,
    parameter int DIV   = 4,
    parameter int NF    = 12,
    parameter int SEED  = 1
) (
    input  logic clk,
    input  logic rst,
    output int   runs,
    output int   fails,
    output logic fin
);
    localparam int BITC = 16 * DIV;
    localparam int PB   = (PAR != 0) ? 1 : 0;
    localparam int FL   = BITC * (1 + DW + PB) + STOPT * DIV;

    logic [DW-1:0] mem [0:63];
    int            wp = 0;
    int            rp = 0;
    int            cyc = 0;
    int            ndone = 0;
    logic [DW-1:0] din;
    logic          nemp, pop, tx, done;

    assign nemp = (wp != rp);
    assign din  = mem[rp[5:0]];

    uart_tx_framer #(
        .DATA_BITS (DW),
        .PARITY    (PAR),
        .STOP_TICKS(STOPT),
        .DIVISOR   (DIV),
        .DIV_W     (9)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .fifo_nempty(nemp),
        .fifo_pop   (pop),
        .tx         (tx),
        .tx_done    (done)
    );

    always @(posedge clk) if (pop) rp <= rp + 1;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (done) ndone <= ndone + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (DW=%0d PAR=%0d STOP=%0d): actual %0d expected %0d",
                     req, DW, PAR, STOPT, act, exp);
        end
    endtask

    function automatic logic par_exp(input logic [DW-1:0] d);
        return (PAR == 1) ? ^d : ~^d;
    endfunction

    // frame monitor
    initial begin
        int t0, tprev;
        bit backlog;
        logic [DW-1:0] got, expv;
        fin = 1'b0;
        tprev = 0;
        backlog = 1'b0;
        @(negedge clk);
        while (rst) @(negedge clk);
        for (int k = 0; k < NF; k++) begin
            @(negedge clk);
            if (k > 0) chk(done == 1'b0, "R8 done width", int'(done), 0);
            while (tx !== 1'b0) @(negedge clk);
            t0 = cyc;
            if (k > 0 && backlog) chk(t0 - tprev == FL, "R9 back-to-back spacing", t0 - tprev, FL);
            tprev = t0;
            expv = mem[k];
            repeat (8 * DIV) @(negedge clk);
            chk(tx == 1'b0, "R4 start bit", int'(tx), 0);
            got = '0;
            for (int i = 0; i < DW; i++) begin
                repeat (BITC) @(negedge clk);
                got[i] = tx;
            end
            chk(got == expv, "R5 data LSB first", int'(got), int'(expv));
            if (PB != 0) begin
                repeat (BITC) @(negedge clk);
                chk(tx == par_exp(expv), "R6 parity bit", int'(tx), int'(par_exp(expv)));
            end
            repeat (BITC) @(negedge clk);
            chk(tx == 1'b1, "R7 stop start", int'(tx), 1);
            repeat (STOPT * DIV - 8 * DIV - 2) @(negedge clk);
            chk(tx == 1'b1 && done == 1'b0, "R7 stop end/R8 early done", int'({tx, done}), 2);
            @(negedge clk);
            chk(done == 1'b1 && cyc - t0 == FL - 1, "R8 done timing R3", cyc - t0, FL - 1);
            chk(tx == 1'b1, "R7 line high at done", int'(tx), 1);
            backlog = nemp;
        end
        fin = 1'b1;
    end

    // stimulus
    initial begin
        int pushed, gap, n;
        bit idle_ok;
        void'($urandom(SEED));
        @(negedge clk);
        chk(tx == 1'b1 && !pop && !done, "R1 reset state", int'({tx, pop, done}), 4);
        while (rst) @(negedge clk);
        idle_ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (tx !== 1'b1 || pop) idle_ok = 1'b0;
        end
        chk(idle_ok, "R2 idle after reset", int'(idle_ok), 1);
        mem[0] = '0;
        mem[1] = '1;
        for (int i = 0; i < DW; i++) mem[2][i] = i[0];
        wp = 3;
        pushed = 3;
        while (pushed < NF) begin
            @(negedge clk);
            while (ndone != pushed) @(negedge clk);
            gap = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(5, 150));
            if (gap > 0) begin
                idle_ok = 1'b1;
                repeat (gap) begin
                    @(negedge clk);
                    if (tx !== 1'b1 || pop) idle_ok = 1'b0;
                end
                chk(idle_ok, "R2 idle gap", int'(idle_ok), 1);
            end
            n = int'($urandom_range(1, 3));
            if (n > NF - pushed) n = NF - pushed;
            for (int i = 0; i < n; i++) begin
                mem[wp[5:0]] = DW'($urandom);
                wp = wp + 1;
            end
            pushed += n;
        end
    end
endmodule

module uart_tx_framer_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   ra, fa, rb, fb, rc, fc;
    logic da, db, dc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_lane #(.DW(8), .PAR(2), .STOPT(16), .DIV(4), .NF(12), .SEED(11)) lane_a (
        .clk(clk), .rst(rst), .runs(ra), .fails(fa), .fin(da));
    tx_lane #(.DW(7), .PAR(1), .STOPT(24), .DIV(3), .NF(12), .SEED(22)) lane_b (
        .clk(clk), .rst(rst), .runs(rb), .fails(fb), .fin(db));
    tx_lane #(.DW(9), .PAR(0), .STOPT(32), .DIV(5), .NF(12), .SEED(33)) lane_c (
        .clk(clk), .rst(rst), .runs(rc), .fails(fc), .fin(dc));

    initial begin
        int cycles;
        int wd;
        cycles = 0;
        wd = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        while (!(da && db && dc) && cycles < 150000) begin
            @(negedge clk);
            cycles++;
        end
        if (!(da && db && dc)) begin
            wd = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("[TB] %0d tests run, %0d failed", ra + rb + rc + wd, fa + fb + fc + wd);
        $finish;
    end
endmodule